// File: doc/BRIEF.md
# Two-Wire Memory Target Bus Front-End

This block is the serial side of a byte-addressed memory that sits on a two-wire bus as a target. A fast system clock oversamples SCL and SDA. It resynchronises both lines and finds SCL edges and bus start and stop events. It assembles bytes MSB first and answers each accepted byte by pulling SDA low for one clock. During reads it shifts out bytes supplied by a memory controller. SDA is open-drain: the block provides only a pull-low enable, and the pad pulls the line low while that enable is high.

The first byte of every transfer selects the target. Its upper nibble must be the device-type code 1010. The next three bits must match the three strap inputs, and the last bit gives the direction. A matching transfer raises a start strobe with the direction beside it. Each later written byte comes out as a one-cycle valid pulse. A read byte is taken from the controller whenever a load strobe pulses. While the memory controller reports that it is busy with an internal write, the block ignores the bus completely.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: A fall of SDA while SCL is high starts a transfer, and a rise of SDA while SCL is high ends it. Each end of transfer seen while not busy gives a one-cycle `stop_o` pulse.
- R2: Bits are taken at SCL rising edges, MSB first. After the eighth bit of a written data byte, `rx_data_o` holds the byte while `rx_valid_o` pulses for one cycle.
- R3: The first byte after a start matches when bits 7:4 equal 4'b1010 and bits 3:1 equal `strap_i[2:0]`. On a match `start_o` pulses once, and `dir_rd_o` is set to bit 0 (1 = read, 0 = write).
- R4: After a matched address byte, and after each written data byte, the target pulls SDA low from the SCL fall that ends the eighth clock to the SCL fall that ends the ninth clock. The pull enable changes only after SCL falls, or on start, stop or busy.
- R5: An address byte that does not match gets no acknowledge and no strobe, and every later byte is ignored until the next start.
- R6: In a read, `tx_data_i` is loaded at the SCL fall that ends each acknowledge clock, and `tx_load_o` pulses then. The byte is put on SDA MSB first, each bit changing after an SCL fall, and SDA is released for the ninth clock.
- R7: If SDA is low at the ninth rising SCL edge of a read byte (controller ACK), the next byte is loaded. If SDA is high (NACK), the target releases SDA and ignores the bus until a start or stop.
- R8: While `busy_i` is high, the target pulls nothing and emits no strobes. It drops any transfer in progress, so bytes sent after `busy_i` falls are ignored until a new start.
- R9: A stop returns the block to idle from any state and releases SDA, even in the middle of a byte. A repeated start without a stop treats the next byte as a new address.
- R10: After reset the pull enable and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| strap_i | input | 3 | Board-strapped address bits compared against address bits 3:1 |
| busy_i | input | 1 | Memory controller busy; the bus is ignored while high |
| tx_data_i | input | 8 | Next byte to send during a read |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain SDA pad |
| start_o | output | 1 | One-cycle pulse on an address match |
| dir_rd_o | output | 1 | Direction of the matched transfer, 1 = read |
| rx_data_o | output | 8 | Last written data byte |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_data_o` is updated |
| tx_load_o | output | 1 | One-cycle pulse when `tx_data_i` is taken |
| stop_o | output | 1 | One-cycle pulse on a stop condition |

## Verification
The bench aims at addresses that differ from a match in only one field: a wrong strap bit, or a wrong type nibble. A comparator that checks only part of the word would acknowledge these. A decoder that forgets the mismatch would accept the data bytes that follow. Separate tests cover a stop in the middle of a byte, a repeated start in a write, and a controller NACK in a read. A design that does not reset its bit count would misalign the next address. One that keeps driving after a NACK would corrupt bytes on the bus. The busy input is raised both before and during a transfer. A target that resumes the transfer when busy falls would accept bytes it must ignore.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_WAIT,
    ST_AACK_DRV,
    ST_WR,
    ST_WACK_WAIT,
    ST_WACK_DRV,
    ST_RD,
    ST_RACK_RISE,
    ST_RACK_FALL
  } tgt_state_e;

  // Device select: type nibble and strap bits must both agree.
  function automatic logic addr_hit(input logic [7:0] word, input logic [2:0] strap);
    return (word[7:4] == DEV_TYPE) && (word[3:1] == strap);
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_tgt_edges.sv
`timescale 1ns/1ps
module i2c_tgt_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_frontend.sv
`timescale 1ns/1ps
module i2c_tgt_frontend
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_pull_o,
  output logic              start_o,
  output logic              dir_rd_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_load_o,
  output logic              stop_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  // Named internal events, visible to the bound checker.
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e state;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] word_in;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_tgt_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign word_in = {sh[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      sda_pull_o <= 1'b0;
      start_o    <= 1'b0;
      dir_rd_o   <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      stop_o     <= 1'b0;
      if (busy_i) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        stop_o     <= 1'b1;
      end else if (start_det) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            sh  <= word_in;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (addr_hit(word_in, strap_i)) begin
                state    <= ST_AACK_WAIT;
                start_o  <= 1'b1;
                dir_rd_o <= sda_s;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK_WAIT: if (scl_fall) begin
            sda_pull_o <= 1'b1;
            state      <= ST_AACK_DRV;
          end
          ST_AACK_DRV: if (scl_fall) begin
            cnt <= '0;
            if (dir_rd_o) begin
              sh         <= tx_data_i;
              sda_pull_o <= ~tx_data_i[BYTE_W-1];
              tx_load_o  <= 1'b1;
              state      <= ST_RD;
            end else begin
              sda_pull_o <= 1'b0;
              state      <= ST_WR;
            end
          end
          ST_WR: if (scl_rise) begin
            sh  <= word_in;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              rx_data_o  <= word_in;
              rx_valid_o <= 1'b1;
              state      <= ST_WACK_WAIT;
            end
          end
          ST_WACK_WAIT: if (scl_fall) begin
            sda_pull_o <= 1'b1;
            state      <= ST_WACK_DRV;
          end
          ST_WACK_DRV: if (scl_fall) begin
            sda_pull_o <= 1'b0;
            cnt        <= '0;
            state      <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_pull_o <= 1'b0;
                state      <= ST_RACK_RISE;
              end else begin
                sh         <= {sh[BYTE_W-2:0], sh[BYTE_W-1]};
                sda_pull_o <= ~sh[BYTE_W-2];
              end
            end
          end
          ST_RACK_RISE: if (scl_rise) begin
            state <= sda_s ? ST_IDLE : ST_RACK_FALL;
          end
          ST_RACK_FALL: if (scl_fall) begin
            sh         <= tx_data_i;
            sda_pull_o <= ~tx_data_i[BYTE_W-1];
            tx_load_o  <= 1'b1;
            cnt        <= '0;
            state      <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_chk.sv
`timescale 1ns/1ps
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       sda_pull_o,
  input logic       start_o,
  input logic       rx_valid_o,
  input logic       tx_load_o,
  input logic       stop_o,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_s,
  input tgt_state_e state
);

  p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_pull_o);

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !(start_o || rx_valid_o || tx_load_o || stop_o));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !busy_i) |=> (!sda_pull_o && stop_o && state == ST_IDLE));

  p_pull_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_det || stop_det || busy_i));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, rx_valid_o, stop_o}));

  p_match_no_early_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !sda_pull_o);

  p_nack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK_RISE && scl_rise && sda_s && !busy_i && !stop_det && !start_det)
      |=> (!sda_pull_o && state == ST_IDLE));

endmodule

bind i2c_tgt_frontend i2c_tgt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .sda_pull_o (sda_pull_o),
  .start_o    (start_o),
  .rx_valid_o (rx_valid_o),
  .tx_load_o  (tx_load_o),
  .stop_o     (stop_o),
  .scl_rise   (scl_rise),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_s      (sda_s),
  .state      (state)
);

// File: tb/test_i2c_tgt_frontend.sv
`timescale 1ns/1ps
module test_i2c_tgt_frontend;

  localparam int Q = 8;   // system clocks per quarter bus bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_c = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       busy = 1'b0;
  logic [7:0] tx_data;
  logic       sda_pull, start_p, dir_rd, rx_valid, tx_load, stop_p;
  logic [7:0] rx_data;
  wire        sda_bus = sda_c & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_rx = 0, n_stop = 0, n_load = 0;
  logic last_dir = 1'b0;
  logic [7:0] rx_log [0:31];

  always #4 clk = ~clk;

  assign tx_data = 8'h96 + 8'(n_load) * 8'h3B;

  i2c_tgt_frontend i_i2c_tgt_frontend (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .tx_data_i(tx_data), .sda_pull_o(sda_pull), .start_o(start_p),
    .dir_rd_o(dir_rd), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_load_o(tx_load), .stop_o(stop_p)
  );

  always @(negedge clk) if (rst_n) begin
    if (start_p)  begin n_start++; last_dir = dir_rd; end
    if (rx_valid) begin rx_log[n_rx % 32] = rx_data; n_rx++; end
    if (stop_p)   n_stop++;
    if (tx_load)  n_load++;
  end

  function automatic logic [7:0] exp_tx(input int k);
    return 8'h96 + 8'(k) * 8'h3B;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; w(Q); scl = 1'b1; w(Q); sda_c = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; w(Q); scl = 1'b1; w(Q); sda_c = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_c = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_c = 1'b1; w(Q); scl = 1'b1; w(Q); ack = ~sda_bus; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_c = 1'b1; w(Q); scl = 1'b1; w(Q); b[i] = sda_bus; w(Q); scl = 1'b0; w(Q);
    end
    send_bit(~give_ack);
  endtask

  // {strap, address byte, expected acknowledge}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 8'hA0, 1'b1}, {3'd0, 8'hA1, 1'b1}, {3'd5, 8'hAA, 1'b1}, {3'd5, 8'hA8, 1'b0},
    {3'd7, 8'hAF, 1'b1}, {3'd7, 8'hBE, 1'b0}, {3'd2, 8'h24, 1'b0}, {3'd3, 8'hA6, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a, a2;
    logic [7:0] d;
    int s0, r0, p0, l0;
    w(5);
    // R10: reset state
    chk("R10 pull in reset", sda_pull, 0);
    chk("R10 strobes in reset", {start_p, rx_valid, tx_load, stop_p}, 0);
    rst_n = 1'b1;
    w(10);
    chk("R10 pull after reset", sda_pull, 0);

    // Table walk: R3 match and direction, R5 mismatch ignored
    for (int i = 0; i < 8; i++) begin
      logic [7:0] adr;
      logic ex;
      strap = VEC[i][11:9]; adr = VEC[i][8:1]; ex = VEC[i][0];
      s0 = n_start; r0 = n_rx;
      bus_start();
      send_byte(adr, a);
      chk("R3 address acknowledge", a, ex);
      chk("R3 start strobe count", n_start - s0, ex);
      if (ex) chk("R3 direction bit", last_dir, adr[0]);
      if (ex && adr[0]) recv_byte(d, 1'b0);
      else begin
        send_byte(8'h00, a2);
        if (!ex) begin
          chk("R5 byte after mismatch ack", a2, 0);
          chk("R5 byte after mismatch rx", n_rx - r0, 0);
        end else chk("R4 data acknowledge", a2, 1);
      end
      bus_stop();
    end

    // R2/R4/R1: write of two bytes
    strap = 3'd4; r0 = n_rx; p0 = n_stop;
    bus_start();
    send_byte(8'hA8, a);  chk("R4 write addr ack", a, 1);
    send_byte(8'h5A, a);  chk("R4 write byte0 ack", a, 1);
    send_byte(8'hC3, a);  chk("R4 write byte1 ack", a, 1);
    chk("R2 rx count", n_rx - r0, 2);
    chk("R2 rx byte0", rx_log[r0 % 32], 8'h5A);
    chk("R2 rx byte1", rx_log[(r0 + 1) % 32], 8'hC3);
    bus_stop();
    chk("R1 stop strobe", n_stop - p0, 1);

    // R6/R7: read with ACK then NACK
    l0 = n_load;
    bus_start();
    send_byte(8'hA9, a);  chk("R6 read addr ack", a, 1);
    recv_byte(d, 1'b1);   chk("R6 read byte0", d, exp_tx(l0));
    recv_byte(d, 1'b0);   chk("R7 read byte1 after ack", d, exp_tx(l0 + 1));
    recv_byte(d, 1'b0);   chk("R7 bus released after nack", d, 8'hFF);
    chk("R7 no load after nack", n_load - l0, 2);
    bus_stop();

    // R9: repeated start inside a write
    s0 = n_start; r0 = n_rx;
    bus_start();
    send_byte(8'hA8, a);
    send_byte(8'h11, a);
    bus_start();
    send_byte(8'hA9, a);  chk("R9 repeated start ack", a, 1);
    chk("R9 repeated start count", n_start - s0, 2);
    chk("R9 repeated start dir", last_dir, 1);
    recv_byte(d, 1'b0);
    bus_stop();
    chk("R9 rx before restart", rx_log[r0 % 32], 8'h11);

    // R9: stop in the middle of a byte
    p0 = n_stop;
    bus_start();
    send_byte(8'hA8, a);
    r0 = n_rx;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    chk("R9 mid-byte stop strobe", n_stop - p0, 1);
    chk("R9 mid-byte stop pull", sda_pull, 0);
    scl = 1'b0; w(Q);
    send_byte(8'hA8, a);  chk("R9 idle after stop ack", a, 0);
    chk("R9 idle after stop rx", n_rx - r0, 0);

    // R8: busy before a transfer
    busy = 1'b1; s0 = n_start; p0 = n_stop; r0 = n_rx;
    bus_start();
    send_byte(8'hA8, a);  chk("R8 busy addr ack", a, 0);
    send_byte(8'h33, a);  chk("R8 busy data ack", a, 0);
    bus_stop();
    chk("R8 busy strobes", {n_start - s0, n_stop - p0, n_rx - r0}, 0);
    busy = 1'b0;

    // R8: busy raised during a transfer
    bus_start();
    send_byte(8'hA8, a);  chk("R8 addr ack before busy", a, 1);
    r0 = n_rx;
    busy = 1'b1;
    send_byte(8'h44, a);  chk("R8 ack while busy", a, 0);
    busy = 1'b0;
    send_byte(8'h55, a);  chk("R8 transfer abandoned", a, 0);
    chk("R8 no rx around busy", n_rx - r0, 0);
    bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule